// File: doc/BRIEF.md
# Three-Level PWM Half-Bridge Gate Sequencer

This block controls one phase of a synchronous buck half-bridge. Its inputs are digital comparator flags. Two of them report the PWM level: above the upper threshold, or below the lower threshold. Others report inductor current direction and whether each MOSFET has actually turned off. From these flags it produces a high-side gate command `drvh` and a low-side gate command `drvl`. A dual-phase driver uses two instances.

A small decoder maps the flags to one of three requests:
- high-side on (`REQ_HIGH`);
- low-side on (`REQ_LOW`);
- both off (`REQ_OFF`).

The middle PWM level selects a power-saving diode-emulation mode. In this mode the low-side switch conducts only while inductor current is positive.

A seven-state sequencer enforces break-before-make. It first releases the conducting switch. It then waits for the off-sense flag of that switch, with a timeout so that it cannot stall. It then counts a fixed dead time before turning the other switch on.

The states are:
- `ST_IDLE`: both gates off.
- `ST_WAIT_LS_OFF`: waiting for the low side to be sensed off.
- `ST_DEAD_TO_HS`: dead time before the high side turns on.
- `ST_HS_ON`: high side on.
- `ST_WAIT_HS_OFF`: waiting for the high side to be sensed off.
- `ST_DEAD_TO_LS`: dead time before the low side turns on.
- `ST_LS_ON`: low side on.

The transitions are:
- **T_IDLE_HI**: `ST_IDLE` to `ST_WAIT_LS_OFF` on `REQ_HIGH`.
- **T_IDLE_LO**: `ST_IDLE` to `ST_WAIT_HS_OFF` on `REQ_LOW`.
- **T_LSOFF_OK**: `ST_WAIT_LS_OFF` to `ST_DEAD_TO_HS` when the low side is sensed off or the timeout expires.
- **T_HSDEAD_DONE**: `ST_DEAD_TO_HS` to `ST_HS_ON` after the dead time.
- **T_HS_LEAVE**: `ST_HS_ON` to `ST_WAIT_HS_OFF` on any request other than `REQ_HIGH`.
- **T_HSOFF_OK**: `ST_WAIT_HS_OFF` to `ST_DEAD_TO_LS` when the high side is sensed off or the timeout expires.
- **T_LSDEAD_DONE**: `ST_DEAD_TO_LS` to `ST_LS_ON` after the dead time.
- **T_LS_LEAVE**: `ST_LS_ON` to `ST_WAIT_LS_OFF` on any request other than `REQ_LOW`.
- **T_ABORT**: any wait or dead-time state to `ST_IDLE` when the request no longer matches the pending turn-on.
- **T_DISABLE**: any state to `ST_IDLE` while `en` is low.

Top module: `gate_phase_ctrl`

## Requirements
- R1: With `pwm_hi`=1 and `pwm_lo`=0, the steady outputs are `drvh`=1 and `drvl`=0.
- R2: With `pwm_lo`=1 and `pwm_hi`=0, the steady outputs are `drvh`=0 and `drvl`=1.
- R3: With both level flags 0 (mid level) and `zcd`=1 (positive current), the steady outputs are `drvh`=0 and `drvl`=1. Starting from all-off, `drvl` first reads 1 after the (DEAD_CYC+2)-th rising edge.
- R4: With both level flags 0 and `zcd`=0, the request is both-off. A conducting low side drops `drvl` after one rising edge and stays off.
- R5: With `pwm_hi` and `pwm_lo` both 1 (an inconsistent input), the request is treated as both-off.
- R6: Turning on the high side from `ST_LS_ON` works as follows. `drvl` falls after one rising edge. The sequencer waits until `ls_off_sense`=1 is sampled. After the next edge it counts DEAD_CYC edges. When the sense flag is already present, `drvh` first reads 1 after the (DEAD_CYC+2)-th edge.
- R7: Turning on the low side from `ST_HS_ON` mirrors R6. `drvh` falls first, the sequencer waits for `hs_off_sense`, and then counts DEAD_CYC edges before `drvl` rises.
- R8: If the off-sense flag never arrives, the wait ends after TIMEOUT_CYC cycles. `drvh` (or `drvl`) first reads 1 after TIMEOUT_CYC+DEAD_CYC+1 edges.
- R9: While `en`=0, both outputs are 0 in the same cycle, whatever the other inputs are. After `en` returns to 1, the full turn-on sequence restarts from all-off.
- R10: `drvh` and `drvl` are never both 1. Each output rises only after the other has been low for at least two sampled cycles.
- R11: If the request changes during a wait or dead-time state, the pending turn-on is abandoned. The sequencer returns to `ST_IDLE` and evaluates the new request from there, so the abandoned gate never pulses.
- R12: During and right after reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Phase enable; low forces both gates off |
| pwm_hi | input | 1 | PWM above upper threshold |
| pwm_lo | input | 1 | PWM below lower threshold |
| zcd | input | 1 | Inductor current positive |
| ls_off_sense | input | 1 | Low-side MOSFET sensed off |
| hs_off_sense | input | 1 | High-side MOSFET sensed off |
| drvh | output | 1 | High-side gate command |
| drvl | output | 1 | Low-side gate command |

## Verification
The bench attacks a request that reverses while a wait or dead time is pending. A sequencer that lacks the abort would finish the stale turn-on and briefly pulse the wrong gate. A sense flag held low exposes a missing timeout, which hangs with both gates off forever. An off-by-one in the timeout or dead-time counter moves the rising edge by one cycle, and the exact-cycle checks catch that. The bench also checks that disable takes effect within the same cycle and that re-enabling restarts the sequence from all-off. A design that did either lazily would leave a gate on for one extra cycle or resume a half-finished turn-on.

// File: rtl/gate_phase_pkg.sv
package gate_phase_pkg;

    typedef enum logic [1:0] {
        REQ_OFF  = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } gate_req_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_WAIT_LS_OFF = 3'd1,
        ST_DEAD_TO_HS  = 3'd2,
        ST_HS_ON       = 3'd3,
        ST_WAIT_HS_OFF = 3'd4,
        ST_DEAD_TO_LS  = 3'd5,
        ST_LS_ON       = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pwm_level_decoder.sv
module pwm_level_decoder
    import gate_phase_pkg::*;
(
    input  logic      pwm_hi,
    input  logic      pwm_lo,
    input  logic      zcd,
    output gate_req_e req
);
    always_comb begin
        unique case ({pwm_hi, pwm_lo})
            2'b10:   req = REQ_HIGH;
            2'b01:   req = REQ_LOW;
            2'b00:   req = zcd ? REQ_LOW : REQ_OFF;
            default: req = REQ_OFF;
        endcase
    end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/deadtime_fsm.sv
module deadtime_fsm
    import gate_phase_pkg::*;
#(
    parameter int DEAD_CYC    = 2,
    parameter int TIMEOUT_CYC = 16,
    parameter int CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  gate_req_e        req,
    input  logic             ls_off,
    input  logic             hs_off,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             drvh,
    output logic             drvl
);
    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e state_q, state_d;
    logic       dead_done, tmo_done;

    assign dead_done = (cnt == DEAD_LAST);
    assign tmo_done  = (cnt == TMO_LAST);
    assign cnt_clr   = (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;                               // T_DISABLE
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req == REQ_HIGH)     state_d = ST_WAIT_LS_OFF;  // T_IDLE_HI
                    else if (req == REQ_LOW) state_d = ST_WAIT_HS_OFF;  // T_IDLE_LO
                end
                ST_WAIT_LS_OFF: begin
                    if (req != REQ_HIGH)          state_d = ST_IDLE;       // T_ABORT
                    else if (ls_off || tmo_done)  state_d = ST_DEAD_TO_HS; // T_LSOFF_OK
                end
                ST_DEAD_TO_HS: begin
                    if (req != REQ_HIGH)  state_d = ST_IDLE;                 // T_ABORT
                    else if (dead_done)   state_d = ST_HS_ON;                // T_HSDEAD_DONE
                end
                ST_HS_ON: begin
                    if (req != REQ_HIGH)  state_d = ST_WAIT_HS_OFF;          // T_HS_LEAVE
                end
                ST_WAIT_HS_OFF: begin
                    if (req != REQ_LOW)           state_d = ST_IDLE;       // T_ABORT
                    else if (hs_off || tmo_done)  state_d = ST_DEAD_TO_LS; // T_HSOFF_OK
                end
                ST_DEAD_TO_LS: begin
                    if (req != REQ_LOW)   state_d = ST_IDLE;                 // T_ABORT
                    else if (dead_done)   state_d = ST_LS_ON;                // T_LSDEAD_DONE
                end
                ST_LS_ON: begin
                    if (req != REQ_LOW)   state_d = ST_WAIT_LS_OFF;          // T_LS_LEAVE
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output decode, gated by enable with no register in between
    always_comb begin
        drvh = 1'b0;
        drvl = 1'b0;
        unique case (state_q)
            ST_HS_ON: drvh = en;
            ST_LS_ON: drvl = en;
            default: begin
                drvh = 1'b0;
                drvl = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gate_phase_ctrl.sv
module gate_phase_ctrl
    import gate_phase_pkg::*;
#(
    parameter int DEAD_CYC    = 2,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic zcd,
    input  logic ls_off_sense,
    input  logic hs_off_sense,
    output logic drvh,
    output logic drvl
);
    localparam int SPAN  = (DEAD_CYC > TIMEOUT_CYC) ? DEAD_CYC : TIMEOUT_CYC;
    localparam int CNT_W = $clog2(SPAN + 1);

    gate_req_e        req;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    pwm_level_decoder u_dec (
        .pwm_hi (pwm_hi),
        .pwm_lo (pwm_lo),
        .zcd    (zcd),
        .req    (req)
    );

    phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    deadtime_fsm #(
        .DEAD_CYC    (DEAD_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .req     (req),
        .ls_off  (ls_off_sense),
        .hs_off  (hs_off_sense),
        .cnt     (cnt),
        .cnt_clr (cnt_clr),
        .drvh    (drvh),
        .drvl    (drvl)
    );
endmodule

// File: rtl/gate_phase_chk.sv
module gate_phase_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic pwm_hi,
    input logic pwm_lo,
    input logic zcd,
    input logic drvh,
    input logic drvl
);
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(drvh && drvl));

    p_hs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drvh) |-> (!$past(drvl) && !$past(drvl, 2)));

    p_ls_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drvl) |-> (!$past(drvh) && !$past(drvh, 2)));

    p_hs_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (drvh && (!pwm_hi || pwm_lo)) |=> !drvh);

    p_ls_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drvl && pwm_hi) |=> !drvl);

    p_diode_emul_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drvl && !pwm_hi && !pwm_lo && !zcd) |=> !drvl);

    p_disable_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!drvh && !drvl));

    p_disable_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drvh && !drvl));
endmodule

bind gate_phase_ctrl gate_phase_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .pwm_hi (pwm_hi),
    .pwm_lo (pwm_lo),
    .zcd    (zcd),
    .drvh   (drvh),
    .drvl   (drvl)
);

// File: tb/test_gate_phase_ctrl.sv
`timescale 1ns/1ps
module test_gate_phase_ctrl;
    localparam int DEAD = 2;
    localparam int TMO  = 16;
    localparam int NVEC = 8;

    // {pwm_hi, pwm_lo, zcd, exp_drvh, exp_drvl}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b100_10,   // R1 high level
        5'b010_01,   // R2 low level
        5'b001_01,   // R3 mid, positive current
        5'b000_00,   // R4 mid, no positive current
        5'b110_00,   // R5 inconsistent flags
        5'b101_10,   // R1 high level, zcd ignored
        5'b001_01,   // R3 mid, positive current again
        5'b010_01    // R2 low level
    };

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0, zcd = 1'b0;
    logic sns_auto = 1'b1, ls_man = 1'b1, hs_man = 1'b1;
    logic ls_off_sense, hs_off_sense, drvh, drvl;
    int   checks = 0, errors = 0;
    logic overlap_seen = 1'b0;

    always #5 clk = ~clk;

    assign ls_off_sense = sns_auto ? !drvl : ls_man;
    assign hs_off_sense = sns_auto ? !drvh : hs_man;

    gate_phase_ctrl #(.DEAD_CYC(DEAD), .TIMEOUT_CYC(TMO)) i_gate_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .zcd(zcd), .ls_off_sense(ls_off_sense), .hs_off_sense(hs_off_sense),
        .drvh(drvh), .drvl(drvl)
    );

    always @(negedge clk) if (rst_n && drvh && drvl) overlap_seen = 1'b1;

    function automatic string vec_tag(int i);
        case (i)
            0, 5:    return "R1";
            1, 7:    return "R2";
            2, 6:    return "R3";
            3:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic eh, logic el);
        checks++;
        if (drvh !== eh || drvl !== el) begin
            errors++;
            $display("FAIL %s: drvh/drvl = %b%b expected %b%b at %0t", tag, drvh, drvl, eh, el, $time);
        end
    endtask

    task automatic set_pwm(logic hi, logic lo, logic z);
        pwm_hi = hi; pwm_lo = lo; zcd = z;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R12 reset state
        step(2);
        chk("R12", 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R12", 1'b0, 1'b0);

        // table walk, steady-state results
        for (int i = 0; i < NVEC; i++) begin
            set_pwm(VEC[i][4], VEC[i][3], VEC[i][2]);
            step(30);
            chk(vec_tag(i), VEC[i][1], VEC[i][0]);
        end

        // R6 exact high-side turn-on timing from ST_LS_ON, sense present
        set_pwm(1, 0, 0);
        step(1);        chk("R6", 1'b0, 1'b0);
        step(DEAD);     chk("R6", 1'b0, 1'b0);
        step(1);        chk("R6", 1'b1, 1'b0);

        // R7 exact low-side turn-on timing from ST_HS_ON
        set_pwm(0, 1, 0);
        step(1);        chk("R7", 1'b0, 1'b0);
        step(DEAD);     chk("R7", 1'b0, 1'b0);
        step(1);        chk("R7", 1'b0, 1'b1);

        // R8 timeout: low-side sense never arrives
        sns_auto = 1'b0; ls_man = 1'b0; hs_man = 1'b1;
        set_pwm(1, 0, 0);
        step(TMO + DEAD); chk("R8", 1'b0, 1'b0);
        step(1);          chk("R8", 1'b1, 1'b0);

        // R6 late sense: turn-on follows the sense edge, not the timeout
        set_pwm(0, 1, 0);
        step(DEAD + 4);   chk("R7", 1'b0, 1'b1);
        ls_man = 1'b0;
        set_pwm(1, 0, 0);
        step(5);          chk("R6", 1'b0, 1'b0);
        ls_man = 1'b1;
        step(DEAD);       chk("R6", 1'b0, 1'b0);
        step(1);          chk("R6", 1'b1, 1'b0);

        // R11 abort during the wait for high-side off
        hs_man = 1'b0;
        set_pwm(0, 1, 0);
        step(3);          chk("R11", 1'b0, 1'b0);
        set_pwm(1, 0, 0);
        step(DEAD + 2);   chk("R11", 1'b0, 1'b0);
        step(1);          chk("R11", 1'b1, 1'b0);

        // R11 abort during the dead time toward the low side
        hs_man = 1'b1;
        set_pwm(0, 1, 0);
        step(2);
        set_pwm(1, 0, 0);
        step(1);          chk("R11", 1'b0, 1'b0);
        step(DEAD + 1);   chk("R11", 1'b0, 1'b0);
        step(1);          chk("R11", 1'b1, 1'b0);

        // R9 disable is immediate and restarts from all-off
        sns_auto = 1'b1;
        en = 1'b0;
        #1;               chk("R9", 1'b0, 1'b0);
        step(3);          chk("R9", 1'b0, 1'b0);
        en = 1'b1;
        step(DEAD + 1);   chk("R9", 1'b0, 1'b0);
        step(1);          chk("R9", 1'b1, 1'b0);

        // R4 diode emulation drops a conducting low side after one edge
        set_pwm(0, 1, 0);
        step(8);          chk("R2", 1'b0, 1'b1);
        set_pwm(0, 0, 0);
        step(1);          chk("R4", 1'b0, 0);
        step(10);         chk("R4", 1'b0, 1'b0);

        // R3 positive current from all-off: low side after DEAD+2 edges
        zcd = 1'b1;
        step(DEAD + 1);   chk("R3", 1'b0, 1'b0);
        step(1);          chk("R3", 1'b0, 1'b1);

        // R10 overlap never observed
        checks++;
        if (overlap_seen) begin
            errors++;
            $display("FAIL R10: overlap seen = 1 expected 0");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule